// File: doc/BRIEF.md
# Differential Phase-Shift Carrier Modulator

This block turns a serial bit stream into a real-valued passband sample stream. Incoming bits are collected into groups of two or three, according to a mode input. Each group is read as a Gray-coded phase step. The step is added to a running phase index modulo eight, so the data sets the change in phase from the previous symbol, not the absolute phase.

The accumulated phase selects an I/Q constellation point. I is multiplied by a cosine carrier and Q by a sine carrier. The difference of the two products is one output sample. Each symbol lasts exactly one carrier period of ten samples, so one symbol produces ten consecutive output samples. When the next bit group is ready in time, symbols follow each other with no gap.

A start-of-packet flag on an input bit makes the group that holds it take phase zero as its reference. An end-of-packet flag closes a partial group, and the missing bits are filled with zeros. Pulse shaping and the converter interface belong to other blocks.

Top module: `dpsk_mod`

## Requirements
- R1: After reset, `samp_o` is 0, `samp_valid_o` is 0 and `bit_ready_o` is 1.
- R2: With `mode_i`=0 a symbol carries 2 bits; with `mode_i`=1 it carries 3 bits. The first bit received becomes the most significant bit of the group.
- R3: A group maps to a phase step in units of 45 degrees, read as a Gray code. In 2-bit mode, 00, 01, 11 and 10 give steps of 0, 2, 4 and 6. In 3-bit mode, 000, 001, 011, 010, 110, 111, 101 and 100 give steps of 0 through 7, in that order.
- R4: The phase index advances by the step modulo 8, and index p stands for an angle of p·45 degrees. The index changes only when a new symbol starts.
- R5: When any bit of a group has `bit_sop_i`=1, the step of that group is added to phase 0 instead of to the previous phase.
- R6: Sample n (0..9) of a symbol with phase index p is (I·C[n] − Q·S[n]) >>> 9, using an arithmetic shift. Here I = round(1024·cos(p·45°)), Q = round(1024·sin(p·45°)), C[n] = round(2047·cos(36°·n)) and S[n] = round(2047·sin(36°·n)). The result is clamped to the signed 14-bit range.
- R7: Every symbol gives exactly 10 consecutive samples with `samp_valid_o`=1. The next symbol follows with no gap when its group is complete before the current symbol's last sample. Otherwise `samp_valid_o` drops to 0 and `samp_o` is 0.
- R8: When the block is idle, the first sample of a group is on `samp_o` two rising edges after the edge that accepts the group's last bit.
- R9: `bit_ready_o` is 0 from the edge that completes a group until the edge at which that group starts its symbol.
- R10: A bit with `bit_last_i`=1 completes its group at once, and the group's missing low bits are zero.
- R11: `mode_i` is taken only when the group register is empty: either at a symbol start or while the block is idle with no bit offered. A change of `mode_i` while a group is partly filled has no effect on that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: four-phase, 2 bits per symbol; 1: eight-phase, 3 bits per symbol |
| bit_valid_i | input | 1 | Input bit is offered |
| bit_i | input | 1 | Data bit |
| bit_sop_i | input | 1 | This bit starts a packet |
| bit_last_i | input | 1 | This bit ends a packet |
| bit_ready_o | output | 1 | Bit is accepted at the next edge when valid |
| samp_o | output | 14 | Signed passband sample |
| samp_valid_o | output | 1 | Sample is part of a symbol |

## Verification
A bit is accepted at the edge where it is offered while `bit_ready_o` is high. From that edge, the bench expects the symbol to start one edge later and its first sample to be visible after a second edge. The bench measures this from a cycle counter that it reads at falling edges, which sit between the edges. Ready is checked at the first falling edge after a group is completed. The end of a run is checked against the first sample: the last valid sample of a two-symbol run must come 19 cycles after it. Sample values are captured at falling edges whenever `samp_valid_o` is high, and the captured stream is compared, in order, with a model built from trigonometric rounding.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
  localparam int SPS   = 10;
  localparam int CNT_W = $clog2(SPS);
  localparam int PH_W  = 3;
  localparam int GRP_W = 3;
  localparam int CAR_W = 12;
  localparam int CON_W = 12;

  typedef logic [PH_W-1:0] phase_t;
  typedef enum logic {MODE_QUAD = 1'b0, MODE_OCT = 1'b1} mode_e;

  // Gray group -> phase step in 45-degree units
  function automatic phase_t gray_step(mode_e m, logic [GRP_W-1:0] g);
    phase_t b;
    if (m == MODE_OCT) begin
      b[2] = g[2];
      b[1] = b[2] ^ g[1];
      b[0] = b[1] ^ g[0];
    end else begin
      b[2] = g[1];
      b[1] = g[1] ^ g[0];
      b[0] = 1'b0;
    end
    return b;
  endfunction
endpackage

// File: rtl/dpsk_gather.sv
module dpsk_gather
  import dpsk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic             sop_i,
  input  logic             last_i,
  input  logic             load_i,
  input  logic             idle_i,
  output logic             ready_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             sop_o,
  output mode_e            mode_o,
  output logic             full_o,
  output logic             partial_o
);
  logic [1:0]       gcnt_q;
  logic [GRP_W-1:0] grp_q;
  logic             gsop_q, full_q;
  mode_e            mode_q;
  logic [1:0]       gmax;
  logic             accept;

  assign gmax   = (mode_q == MODE_OCT) ? 2'd2 : 2'd1;
  assign accept = bit_valid_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q <= '0;
      grp_q  <= '0;
      gsop_q <= 1'b0;
      full_q <= 1'b0;
      mode_q <= MODE_QUAD;
    end else if (load_i) begin
      full_q <= 1'b0;
      grp_q  <= '0;
      gsop_q <= 1'b0;
      mode_q <= mode_i;
    end else begin
      if (idle_i && gcnt_q == 2'd0 && !full_q && !bit_valid_i)
        mode_q <= mode_i;
      if (accept) begin
        grp_q[gmax - gcnt_q] <= bit_i;
        gsop_q <= gsop_q | sop_i;
        if (gcnt_q == gmax || last_i) begin
          full_q <= 1'b1;
          gcnt_q <= '0;
        end else begin
          gcnt_q <= gcnt_q + 2'd1;
        end
      end
    end
  end

  assign ready_o   = !full_q;
  assign grp_o     = grp_q;
  assign sop_o     = gsop_q;
  assign mode_o    = mode_q;
  assign full_o    = full_q;
  assign partial_o = (gcnt_q != 2'd0);
endmodule

// File: rtl/dpsk_phase.sv
module dpsk_phase
  import dpsk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             sop_i,
  input  mode_e            mode_i,
  output logic             load_o,
  output logic             idle_o,
  output logic             wrap_o,
  output logic             active_o,
  output phase_t           phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  phase_t           phase_q;
  logic             wrap, load;

  assign wrap = active_q && (cnt_q == CNT_W'(SPS - 1));
  assign load = (!active_q || wrap) && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      phase_q  <= '0;
    end else if (load) begin
      phase_q  <= (sop_i ? phase_t'(0) : phase_q) + gray_step(mode_i, grp_i);
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (wrap) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assign load_o   = load;
  assign idle_o   = !active_q;
  assign wrap_o   = wrap;
  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/dpsk_mixer.sv
module dpsk_mixer
  import dpsk_pkg::*;
#(
  parameter int OUT_W = 14,
  parameter int SHIFT = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    active_i,
  input  phase_t                  phase_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic signed [OUT_W-1:0] samp_o,
  output logic                    valid_o
);
  localparam int SUM_W = CAR_W + CON_W + 1;
  localparam int OMAX  = 2**(OUT_W-1) - 1;
  localparam int OMIN  = -(2**(OUT_W-1));

  function automatic logic signed [CAR_W-1:0] car_cos(logic [CNT_W-1:0] n);
    case (n)
      0: return 12'sd2047;  1: return 12'sd1656;  2: return 12'sd633;
      3: return -12'sd633;  4: return -12'sd1656; 5: return -12'sd2047;
      6: return -12'sd1656; 7: return -12'sd633;  8: return 12'sd633;
      9: return 12'sd1656;  default: return '0;
    endcase
  endfunction

  function automatic logic signed [CAR_W-1:0] car_sin(logic [CNT_W-1:0] n);
    case (n)
      1: return 12'sd1203;  2: return 12'sd1947;  3: return 12'sd1947;
      4: return 12'sd1203;  6: return -12'sd1203; 7: return -12'sd1947;
      8: return -12'sd1947; 9: return -12'sd1203; default: return '0;
    endcase
  endfunction

  // constellation on a 1024 scale
  function automatic logic signed [CON_W-1:0] con_cos(phase_t p);
    case (p)
      0: return 12'sd1024; 1: return 12'sd724;   2: return 12'sd0;
      3: return -12'sd724; 4: return -12'sd1024; 5: return -12'sd724;
      6: return 12'sd0;    default: return 12'sd724;
    endcase
  endfunction

  function automatic logic signed [CON_W-1:0] con_sin(phase_t p);
    return con_cos(p - phase_t'(2));
  endfunction

  logic signed [SUM_W-1:0] prod_i, prod_q, diff, shr;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    prod_i = SUM_W'(con_cos(phase_i)) * SUM_W'(car_cos(cnt_i));
    prod_q = SUM_W'(con_sin(phase_i)) * SUM_W'(car_sin(cnt_i));
    diff   = prod_i - prod_q;
    shr    = diff >>> SHIFT;
    if (int'(shr) > OMAX)      sat = OUT_W'(OMAX);
    else if (int'(shr) < OMIN) sat = OUT_W'(OMIN);
    else                       sat = OUT_W'(shr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      samp_o  <= active_i ? sat : '0;
      valid_o <= active_i;
    end
  end
endmodule

// File: rtl/dpsk_mod.sv
module dpsk_mod
  import dpsk_pkg::*;
#(
  parameter int OUT_W = 14,
  parameter int SHIFT = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_i,
  input  logic                    bit_valid_i,
  input  logic                    bit_i,
  input  logic                    bit_sop_i,
  input  logic                    bit_last_i,
  output logic                    bit_ready_o,
  output logic signed [OUT_W-1:0] samp_o,
  output logic                    samp_valid_o
);
  logic [GRP_W-1:0] grp;
  logic             grp_sop, grp_full, grp_partial;
  mode_e            grp_mode;
  logic             load, idle, wrap, active;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  dpsk_gather u_gather (
    .clk_i, .rst_ni,
    .mode_i      (mode_e'(mode_i)),
    .bit_valid_i,
    .bit_i,
    .sop_i       (bit_sop_i),
    .last_i      (bit_last_i),
    .load_i      (load),
    .idle_i      (idle),
    .ready_o     (bit_ready_o),
    .grp_o       (grp),
    .sop_o       (grp_sop),
    .mode_o      (grp_mode),
    .full_o      (grp_full),
    .partial_o   (grp_partial)
  );

  dpsk_phase u_phase (
    .clk_i, .rst_ni,
    .full_i   (grp_full),
    .grp_i    (grp),
    .sop_i    (grp_sop),
    .mode_i   (grp_mode),
    .load_o   (load),
    .idle_o   (idle),
    .wrap_o   (wrap),
    .active_o (active),
    .phase_o  (phase),
    .cnt_o    (cnt)
  );

  dpsk_mixer #(.OUT_W(OUT_W), .SHIFT(SHIFT)) u_mixer (
    .clk_i, .rst_ni,
    .active_i (active),
    .phase_i  (phase),
    .cnt_i    (cnt),
    .samp_o,
    .valid_o  (samp_valid_o)
  );
endmodule

// File: rtl/dpsk_mod_chk.sv
module dpsk_mod_chk
  import dpsk_pkg::*;
#(
  parameter int OUT_W = 14
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    samp_valid_o,
  input logic signed [OUT_W-1:0] samp_o,
  input logic                    bit_ready_o,
  input logic                    load,
  input logic                    wrap,
  input logic                    active,
  input logic [PH_W-1:0]         phase,
  input logic                    grp_partial,
  input logic                    grp_mode
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    run_q <= '0;
    else if (!samp_valid_o)                         run_q <= '0;
    else if (run_q == CNT_W'(SPS - 1))              run_q <= '0;
    else                                            run_q <= run_q + CNT_W'(1);
  end

  a_r7_whole_symbols: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(samp_valid_o) |-> run_q == '0);

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_valid_o |-> samp_o == '0);

  a_r4_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !wrap) |=> $stable(phase));

  a_r9_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_ready_o && !load) |=> !bit_ready_o);

  a_r11_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_partial |=> $stable(grp_mode));
endmodule

bind dpsk_mod dpsk_mod_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .samp_valid_o (samp_valid_o),
  .samp_o       (samp_o),
  .bit_ready_o  (bit_ready_o),
  .load         (load),
  .wrap         (wrap),
  .active       (active),
  .phase        (phase),
  .grp_partial  (grp_partial),
  .grp_mode     (grp_mode)
);

// File: tb/sim_dpsk_mod.sv
module sim_dpsk_mod;
  localparam int CLK_P = 10;
  localparam int OUT_W = 14;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, bit_sop_i = 1'b0, bit_last_i = 1'b0;
  logic bit_ready_o, samp_valid_o;
  logic signed [OUT_W-1:0] samp_o;

  int checks = 0, fails = 0, cyc = 0;
  int cap [0:511];
  int expv[0:511];
  int cap_n = 0, exp_n = 0, first_c = 0, last_c = 0;
  bit tx [0:63];
  int g2b4 [0:3] = '{0, 1, 3, 2};
  int g2b8 [0:7] = '{0, 1, 3, 2, 7, 6, 4, 5};

  dpsk_mod u0 (.clk_i(clk), .rst_ni, .mode_i, .bit_valid_i, .bit_i, .bit_sop_i,
               .bit_last_i, .bit_ready_o, .samp_o, .samp_valid_o);

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (samp_valid_o) begin
      if (cap_n == 0) first_c = cyc;
      last_c = cyc;
      if (cap_n < 512) cap[cap_n] = int'(samp_o);
      cap_n++;
    end
  end

  task automatic chk(string tag, int act, int expct);
    checks++;
    if (act != expct) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expct);
    end
  endtask

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic load_tx(logic [63:0] v, int n);
    for (int i = 0; i < n; i++) tx[i] = v[n-1-i];
  endtask

  // expected samples for one packet from tx[0..n-1]
  task automatic add_pkt(bit m8, int n);
    int p = 0;
    int gs = m8 ? 3 : 2;
    for (int i = 0; i < n; i += gs) begin
      int g = 0;
      for (int j = 0; j < gs; j++) g = g * 2 + ((i + j < n) ? int'(tx[i+j]) : 0);
      p = (p + (m8 ? g2b8[g] : 2 * g2b4[g])) % 8;
      for (int k = 0; k < 10; k++) begin
        int ci = rnd(1024.0 * $cos(p * PI / 4.0));
        int si = rnd(1024.0 * $sin(p * PI / 4.0));
        int cc = rnd(2047.0 * $cos(2.0 * PI * k / 10.0));
        int ss = rnd(2047.0 * $sin(2.0 * PI * k / 10.0));
        int v  = (ci * cc - si * ss) >>> 9;
        if (v > 8191) v = 8191;
        if (v < -8192) v = -8192;
        expv[exp_n++] = v;
      end
    end
  endtask

  task automatic send_bit(bit b, bit sop, bit last);
    @(negedge clk);
    bit_valid_i = 1'b1; bit_i = b; bit_sop_i = sop; bit_last_i = last;
    while (!bit_ready_o) @(negedge clk);
    @(posedge clk);
    #1 bit_valid_i = 1'b0; bit_sop_i = 1'b0; bit_last_i = 1'b0;
  endtask

  task automatic send_pkt(int n);
    for (int i = 0; i < n; i++) send_bit(tx[i], i == 0, i == n - 1);
  endtask

  task automatic set_mode(bit m);
    @(negedge clk) mode_i = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic begin_case();
    @(negedge clk);
    cap_n = 0; exp_n = 0;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic cmp_stream(string tag);
    chk({tag, " sample count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) chk(tag, cap[i], expv[i]);
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", int'(samp_valid_o), 0);
    chk("R1 sample after reset", int'(samp_o), 0);
    chk("R1 ready after reset", int'(bit_ready_o), 1);
  endtask

  task automatic t_latency();
    int t0;
    set_mode(1'b0);
    begin_case();
    load_tx(64'b0111, 4);
    send_bit(1'b0, 1'b1, 1'b0);
    send_bit(1'b1, 1'b0, 1'b0);
    @(negedge clk) t0 = cyc;
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 ready low while group waits", int'(bit_ready_o), 0);
    drain();
    chk("R8 first sample delay", first_c - t0, 2);
    chk("R7 two symbols back to back", last_c - first_c, 19);
    chk("R7 idle valid", int'(samp_valid_o), 0);
    chk("R7 idle sample", int'(samp_o), 0);
    add_pkt(1'b0, 4);
    cmp_stream("R6 latency packet");
  endtask

  task automatic t_quad();
    set_mode(1'b0);
    begin_case();
    load_tx(64'b0101010100111010, 16);
    send_pkt(16);
    drain();
    add_pkt(1'b0, 16);
    cmp_stream("R2 R3 R4 R6 four-phase");
  endtask

  task automatic t_oct();
    set_mode(1'b1);
    begin_case();
    load_tx(64'b000001010011100101110111, 24);
    send_pkt(24);
    drain();
    add_pkt(1'b1, 24);
    cmp_stream("R2 R3 R4 R6 eight-phase");
  endtask

  task automatic t_sop();
    set_mode(1'b1);
    begin_case();
    load_tx(64'b011, 3);
    send_pkt(3);
    send_pkt(3);
    drain();
    add_pkt(1'b1, 3);
    add_pkt(1'b1, 3);
    cmp_stream("R5 packet restart");
    chk("R5 second packet repeats first symbol", cap[13], cap[3]);
  endtask

  task automatic t_pad();
    set_mode(1'b1);
    begin_case();
    load_tx(64'b0111, 4);
    send_pkt(4);
    drain();
    add_pkt(1'b1, 4);
    cmp_stream("R10 eight-phase pad");
    set_mode(1'b0);
    begin_case();
    load_tx(64'b111, 3);
    send_pkt(3);
    drain();
    add_pkt(1'b0, 3);
    cmp_stream("R10 four-phase pad");
  endtask

  task automatic t_mode_hold();
    set_mode(1'b1);
    begin_case();
    load_tx(64'b101, 3);
    send_bit(1'b1, 1'b1, 1'b0);
    @(negedge clk) mode_i = 1'b0;
    send_bit(1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b1);
    drain();
    add_pkt(1'b1, 3);
    cmp_stream("R11 mode change mid-group");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_quad();
    t_oct();
    t_sop();
    t_pad();
    t_mode_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule